// File: doc/BRIEF.md
# Line-Interface Reset Sequencer

This block is the reset controller for a four-channel line-interface device. It combines three reset sources into one internal reset: a power-good indication, an active-low external reset pin, and a soft-reset bit in the host-writable global configuration register. Each source starts a timed internal sequence. The sequence counts rising edges of the reference clock, which is sampled by a free-running system clock. While any sequence is in progress, the block holds the configuration register file in reset, so that every register returns to its default value. For the same period it disables every output driver of the device.

The power-on sequence is long, about 300 ms, and moves forward only while the reference clock toggles. If the reference clock is absent, the device stays in reset. A pin or soft reset uses a short sequence of about 5 µs. An edge on the pin asserts reset at once, and its release passes through a two-flop synchronizer. Any new request restarts the count. Once the sequence completes, the output enables follow the strap mode:

- Hardware mode drives the three reference clock outputs and the interrupt pin.
- Host mode leaves those outputs in high impedance.
- The transmit clock pins are inputs in both modes.

Top module: `lirst_sequencer`

## Requirements
- R1: After `supply_ok` rises with the reference clock running, `reset_done` and `cfg_rst_n` stay low and then rise once POR_TICKS reference rising edges have been counted. POR_TICKS is REF_KHZ*POR_US/1000. This takes between (N-1) and N reference periods, plus up to 8 system clocks of synchronizer latency, with N = POR_TICKS.
- R2: With no reference edges, the sequence stalls and `reset_done` stays low indefinitely. `ref_missing` goes high once MISS_CYCLES system clocks pass without a reference edge, and it returns low after edges resume.
- R3: While `rst_pin_n` is low, the following outputs are low immediately and without a clock: `cfg_rst_n`, `reset_done`, every bit of `chan_oe`, `misc_oe`, `clkout_oe` and `irq_oe`. An output enable of 0 means the driver is in high impedance.
- R4: After `rst_pin_n` returns high, `reset_done` rises within the R1 window, using N = SHORT_TICKS = REF_KHZ*SHORT_US/1000 with a minimum of 1.
- R5: In host mode (`host_mode`=1), a write with `cfg_addr`=0x01 and bit 0 of `cfg_wdata` set starts a soft reset. `reset_done` is low at the next clock and rises again within the R4 window, measured from that write. The bit is not stored.
- R6: A write has no effect on `reset_done` in three cases: it targets another address, it has bit 0 clear, or it occurs in hardware mode.
- R7: A soft-reset write made while a sequence is counting restarts the count, so completion is timed from the latest write.
- R8: `chan_oe` and `misc_oe` equal `reset_done`. When `host_mode`=0, `clkout_oe` and `irq_oe` equal `reset_done`. When `host_mode`=1, `clkout_oe` and `irq_oe` are 0.
- R9: `tclk_oe` is 0 at all times, so the transmit clock pins always act as inputs.
- R10: If the pin is held low while power comes up, the first sequence after the pin is released uses the power-on length POR_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| supply_ok | input | 1 | Digital supply-good indication, low = power not good |
| rst_pin_n | input | 1 | External hard reset pin, active low, asynchronous |
| ref_clk | input | 1 | Reference clock, sampled as data |
| host_mode | input | 1 | Strap: 1 = host mode, 0 = hardware mode |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rst_n | output | 1 | Active-low reset to the configuration register file |
| reset_done | output | 1 | Internal reset sequence complete |
| ref_missing | output | 1 | No reference edge seen for MISS_CYCLES clocks |
| chan_oe | output | CHANNELS | Per-channel enable for data, clock, line-driver and status-flag outputs |
| misc_oe | output | 1 | Enable for serial data out and test data out |
| clkout_oe | output | CLKOUTS | Enables for the reference clock outputs |
| irq_oe | output | 1 | Enable for the interrupt pin |
| tclk_oe | output | CHANNELS | Drive enables for the transmit clock pins (always 0) |

## Verification
The bench does not predict the exact cycle on which a timed reset completes, because a reference edge crosses two synchronizer flops and an edge detector first. It therefore counts system clocks from the releasing stimulus until `reset_done` is seen high. That count must lie between (N-1)·8 and N·8+8 clocks, since the bench reference period is 8 clocks. A soft-reset write must show `reset_done` low at the first falling edge after the capturing edge. The pin effect is asynchronous and is sampled 1 ns after the pin falls. An ignored write is judged by watching `reset_done` for several further clocks. All samples are taken on falling edges, halfway between active edges.

// File: rtl/lirst_pkg.sv
package lirst_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_COUNT = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/lirst_sync.sv
module lirst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;
  logic [STAGES-1:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr <= '0;
    else         sr <= sr_nxt;
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/lirst_refmon.sv
module lirst_refmon #(
  parameter int MISS_CYCLES = 64
) (
  input  logic clk,
  input  logic arst_n,
  input  logic ref_clk,
  output logic tick,
  output logic ref_missing
);

  localparam int MISS_W = $clog2(MISS_CYCLES + 1);
  localparam logic [MISS_W-1:0] MISS_LIM = MISS_W'(MISS_CYCLES);

  logic              ref_q;
  logic              ref_d;
  logic [MISS_W-1:0] miss_cnt;
  logic [MISS_W-1:0] miss_nxt;

  lirst_sync #(.STAGES(2)) u_ref_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (ref_clk),
    .q      (ref_q)
  );

  assign tick        = ref_q & ~ref_d;
  assign ref_missing = (miss_cnt == MISS_LIM);

  always_comb begin
    miss_nxt = miss_cnt;
    if (tick)              miss_nxt = '0;
    else if (!ref_missing) miss_nxt = miss_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ref_d    <= 1'b0;
      miss_cnt <= '0;
    end else begin
      ref_d    <= ref_q;
      miss_cnt <= miss_nxt;
    end
  end

  // R2: an edge always clears the missing flag on the next cycle
  a_r2_tick_clears_missing: assert property (@(posedge clk) disable iff (!arst_n)
    tick |=> !ref_missing);

  // R2: the flag stays up until an edge arrives
  a_r2_missing_sticks: assert property (@(posedge clk) disable iff (!arst_n)
    (ref_missing && !tick) |=> ref_missing);

endmodule

// File: rtl/lirst_timer.sv
module lirst_timer
  import lirst_pkg::*;
#(
  parameter int unsigned POR_TICKS   = 614400,
  parameter int unsigned SHORT_TICKS = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic por_n,
  input  logic hold_n,
  input  logic soft_req,
  input  logic tick,
  output logic done
);

  localparam int CNT_W = $clog2(POR_TICKS + 1);
  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

  seq_state_e       state;
  seq_state_e       state_nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] last;
  logic             por_pend;
  logic             por_clr;

  assign last = por_pend ? POR_LAST : SHORT_LAST;
  assign done = (state == SEQ_RUN);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    por_clr   = 1'b0;
    case (state)
      SEQ_HOLD: begin
        if (hold_n) begin
          state_nxt = SEQ_COUNT;
          cnt_nxt   = '0;
        end
      end
      SEQ_COUNT: begin
        if (soft_req) begin
          cnt_nxt = '0;
        end else if (tick) begin
          if (cnt == last) begin
            state_nxt = SEQ_RUN;
            cnt_nxt   = '0;
            por_clr   = 1'b1;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
      end
      SEQ_RUN: begin
        if (soft_req) begin
          state_nxt = SEQ_COUNT;
          cnt_nxt   = '0;
        end
      end
      default: state_nxt = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
    end
  end

  // power-on pending flag survives pin and soft resets
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       por_pend <= 1'b1;
    else if (por_clr) por_pend <= 1'b0;
  end

  // R7: a soft request restarts counting from zero
  a_r7_soft_restart: assert property (@(posedge clk) disable iff (!arst_n)
    (soft_req && state != SEQ_HOLD) |=> (state == SEQ_COUNT && cnt == '0));

  // R4: the count never passes the active terminal value
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!arst_n)
    (state == SEQ_COUNT) |-> (cnt <= last));

  // R1: completion only follows a reference edge
  a_r1_done_on_tick: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(done) |-> $past(tick));

  // R3: a synchronizer still holding keeps the sequence idle
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!arst_n)
    !hold_n |=> !done);

endmodule

// File: rtl/lirst_oe.sv
module lirst_oe #(
  parameter int CHANNELS = 4,
  parameter int CLKOUTS  = 3
) (
  input  logic                done,
  input  logic                host_mode,
  output logic [CHANNELS-1:0] chan_oe,
  output logic                misc_oe,
  output logic [CLKOUTS-1:0]  clkout_oe,
  output logic                irq_oe,
  output logic [CHANNELS-1:0] tclk_oe
);

  logic hw_en;

  assign hw_en   = done & ~host_mode;
  assign misc_oe = done;
  assign irq_oe  = hw_en;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    assign chan_oe[i] = done;
    assign tclk_oe[i] = 1'b0;
  end

  for (genvar k = 0; k < CLKOUTS; k++) begin : g_clk
    assign clkout_oe[k] = hw_en;
  end

endmodule

// File: rtl/lirst_sequencer.sv
module lirst_sequencer
  import lirst_pkg::*;
#(
  parameter int          CHANNELS    = 4,
  parameter int          CLKOUTS     = 3,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter int unsigned GCR_ADDR    = 1,
  parameter int          SOFT_BIT    = 0,
  parameter int unsigned REF_KHZ     = 2048,
  parameter int unsigned POR_US      = 300000,
  parameter int unsigned SHORT_US    = 5,
  parameter int          MISS_CYCLES = 64
) (
  input  logic                clk,
  input  logic                supply_ok,
  input  logic                rst_pin_n,
  input  logic                ref_clk,
  input  logic                host_mode,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic                cfg_rst_n,
  output logic                reset_done,
  output logic                ref_missing,
  output logic [CHANNELS-1:0] chan_oe,
  output logic                misc_oe,
  output logic [CLKOUTS-1:0]  clkout_oe,
  output logic                irq_oe,
  output logic [CHANNELS-1:0] tclk_oe
);

  localparam longint unsigned POR_PROD   = longint'(REF_KHZ) * longint'(POR_US);
  localparam longint unsigned SHORT_PROD = longint'(REF_KHZ) * longint'(SHORT_US);
  localparam int unsigned POR_RAW     = int'(POR_PROD / 64'd1000);
  localparam int unsigned SHORT_RAW   = int'(SHORT_PROD / 64'd1000);
  localparam int unsigned SHORT_TICKS = (SHORT_RAW == 0) ? 1 : SHORT_RAW;
  localparam int unsigned POR_TICKS   = (POR_RAW < SHORT_TICKS) ? SHORT_TICKS : POR_RAW;
  localparam logic [ADDR_W-1:0] GCR_A = ADDR_W'(GCR_ADDR);

  logic arst_n;
  logic por_n;
  logic hold_n;
  logic tick;
  logic soft_req;
  logic done;

  assign arst_n   = supply_ok & rst_pin_n;
  assign soft_req = host_mode & cfg_wr & (cfg_addr == GCR_A) & cfg_wdata[SOFT_BIT];

  lirst_sync #(.STAGES(2)) u_por_sync (
    .clk    (clk),
    .arst_n (supply_ok),
    .d      (1'b1),
    .q      (por_n)
  );

  lirst_sync #(.STAGES(2)) u_hold_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (1'b1),
    .q      (hold_n)
  );

  lirst_refmon #(.MISS_CYCLES(MISS_CYCLES)) u_refmon (
    .clk         (clk),
    .arst_n      (por_n),
    .ref_clk     (ref_clk),
    .tick        (tick),
    .ref_missing (ref_missing)
  );

  lirst_timer #(
    .POR_TICKS   (POR_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
  ) u_timer (
    .clk      (clk),
    .arst_n   (arst_n),
    .por_n    (por_n),
    .hold_n   (hold_n),
    .soft_req (soft_req),
    .tick     (tick),
    .done     (done)
  );

  lirst_oe #(
    .CHANNELS (CHANNELS),
    .CLKOUTS  (CLKOUTS)
  ) u_oe (
    .done      (done),
    .host_mode (host_mode),
    .chan_oe   (chan_oe),
    .misc_oe   (misc_oe),
    .clkout_oe (clkout_oe),
    .irq_oe    (irq_oe),
    .tclk_oe   (tclk_oe)
  );

  assign cfg_rst_n  = done;
  assign reset_done = done;

  // R3: a low pin keeps every driver off and the register file in reset
  a_r3_pin_quiets: assert property (@(posedge clk) disable iff (!supply_ok)
    !rst_pin_n |-> (!cfg_rst_n && chan_oe == '0 && !misc_oe && !irq_oe));

  // R8: host mode never drives clock outputs or the interrupt pin
  a_r8_host_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    host_mode |-> (clkout_oe == '0 && !irq_oe));

  // R5: an accepted soft write drops completion on the next cycle
  a_r5_soft_drops: assert property (@(posedge clk) disable iff (!arst_n)
    (soft_req && reset_done) |=> !reset_done);

endmodule

// File: tb/tb_lirst_sequencer.sv
`timescale 1ns/1ps
module tb_lirst_sequencer;

  localparam int CH       = 4;
  localparam int NCLK     = 3;
  localparam int REF_KHZ  = 1000;
  localparam int POR_US   = 200;
  localparam int SHORT_US = 10;
  localparam int MISS     = 32;
  localparam int POR_N    = REF_KHZ * POR_US / 1000;
  localparam int SHORT_N  = REF_KHZ * SHORT_US / 1000;
  localparam int REF_HALF = 4;
  localparam int REF_PER  = 2 * REF_HALF;
  localparam int OW       = 2 + CH + 1 + NCLK + 1 + CH;

  logic clk = 1'b0;
  logic supply_ok, rst_pin_n, ref_clk, host_mode, cfg_wr;
  logic [7:0] cfg_addr, cfg_wdata;
  logic cfg_rst_n, reset_done, ref_missing, misc_oe, irq_oe;
  logic [CH-1:0] chan_oe, tclk_oe;
  logic [NCLK-1:0] clkout_oe;

  int checks = 0;
  int errors = 0;
  bit ref_run = 1'b0;
  int ref_div = 0;

  lirst_sequencer #(
    .CHANNELS(CH), .CLKOUTS(NCLK), .ADDR_W(8), .DATA_W(8), .GCR_ADDR(1), .SOFT_BIT(0),
    .REF_KHZ(REF_KHZ), .POR_US(POR_US), .SHORT_US(SHORT_US), .MISS_CYCLES(MISS)
  ) dut (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n), .ref_clk(ref_clk),
    .host_mode(host_mode), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rst_n(cfg_rst_n), .reset_done(reset_done), .ref_missing(ref_missing),
    .chan_oe(chan_oe), .misc_oe(misc_oe), .clkout_oe(clkout_oe), .irq_oe(irq_oe),
    .tclk_oe(tclk_oe)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (ref_run) begin
      if (ref_div == REF_HALF - 1) begin
        ref_div <= 0;
        ref_clk <= ~ref_clk;
      end else begin
        ref_div <= ref_div + 1;
      end
    end
  end

  function automatic int win_lo(int n);
    return (n - 1) * REF_PER;
  endfunction

  function automatic int win_hi(int n);
    return n * REF_PER + 8;
  endfunction

  function automatic logic [OW-1:0] exp_outs(bit d, bit host);
    logic [NCLK-1:0] ck;
    ck = host ? '0 : {NCLK{d}};
    return {d, d, {CH{d}}, d, ck, d & ~host, {CH{1'b0}}};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(string req, bit d);
    logic [OW-1:0] act;
    logic [OW-1:0] exp;
    act = {cfg_rst_n, reset_done, chan_oe, misc_oe, clkout_oe, irq_oe, tclk_oe};
    exp = exp_outs(d, host_mode);
    chk(act === exp, req, "outputs", int'(act), int'(exp));
    chk(tclk_oe === '0, "R9", "tclk_oe", int'(tclk_oe), 0);
  endtask

  task automatic chk_win(string req, int n, int len);
    chk(n >= win_lo(len) && n <= win_hi(len), req, "cycles to done", n, win_lo(len));
  endtask

  task automatic measure(output int n);
    n = 0;
    while (reset_done !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic soft_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pin_pulse(int len);
    int n;
    @(negedge clk);
    rst_pin_n = 1'b0;
    #1;
    chk_outs("R3", 1'b0);
    repeat (len) @(negedge clk);
    chk_outs("R3", 1'b0);
    rst_pin_n = 1'b1;
    measure(n);
    chk_win("R4", n, SHORT_N);
  endtask

  task automatic stay_done(string req);
    repeat (5) begin
      @(negedge clk);
      chk(reset_done === 1'b1, req, "reset_done stays", int'(reset_done), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    supply_ok = 1'b0; rst_pin_n = 1'b1; ref_clk = 1'b0; host_mode = 1'b1;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    void'($urandom(32'd2718));
    ref_run = 1'b1;
    repeat (5) @(negedge clk);
    chk_outs("R1", 1'b0);
    chk(ref_missing === 1'b0, "R2", "missing in power down", int'(ref_missing), 0);

    // R1 power-on
    supply_ok = 1'b1;
    measure(n);
    chk_win("R1", n, POR_N);
    chk_outs("R8", 1'b1);

    // R8 hardware mode enables
    host_mode = 1'b0;
    #1;
    chk_outs("R8", 1'b1);

    // R6 soft write ignored in hardware mode
    soft_write(8'h01, 8'h01);
    stay_done("R6");
    host_mode = 1'b1;
    soft_write(8'h02, 8'h01);
    stay_done("R6");
    soft_write(8'h01, 8'hFE);
    stay_done("R6");

    // R5 accepted soft reset
    soft_write(8'h01, 8'h01);
    chk_outs("R5", 1'b0);
    measure(n);
    chk_win("R5", n, SHORT_N);

    // R7 restart during counting
    soft_write(8'h01, 8'h01);
    repeat (40) @(negedge clk);
    chk(reset_done === 1'b0, "R7", "still counting", int'(reset_done), 0);
    soft_write(8'h01, 8'h01);
    measure(n);
    chk_win("R7", n, SHORT_N);

    // R3 / R4 pin reset
    pin_pulse(7);

    // R2 missing reference clock
    ref_run = 1'b0;
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(reset_done === 1'b0, "R2", "stalled done", int'(reset_done), 0);
    chk(ref_missing === 1'b1, "R2", "missing flag", int'(ref_missing), 1);
    repeat (300) @(negedge clk);
    chk(reset_done === 1'b0, "R2", "still stalled", int'(reset_done), 0);
    ref_run = 1'b1;
    measure(n);
    chk_win("R2", n, SHORT_N);
    chk(ref_missing === 1'b0, "R2", "missing cleared", int'(ref_missing), 0);

    // R10 pin held through power-up
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk_outs("R10", 1'b0);
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b0;
    supply_ok = 1'b1;
    repeat (30) @(negedge clk);
    chk_outs("R3", 1'b0);
    rst_pin_n = 1'b1;
    measure(n);
    chk_win("R10", n, POR_N);

    // random mix
    for (int it = 0; it < 16; it++) begin
      int op;
      op = int'($urandom % 3);
      host_mode = 1'($urandom % 2);
      if (op == 0) begin
        pin_pulse(1 + int'($urandom % 20));
      end else if (op == 1) begin
        logic [7:0] a;
        logic [7:0] d;
        bit trig;
        a = ($urandom % 2 == 0) ? 8'h01 : 8'($urandom % 8);
        d = 8'($urandom);
        trig = host_mode && a == 8'h01 && d[0];
        soft_write(a, d);
        if (trig) begin
          chk_outs("R5", 1'b0);
          measure(n);
          chk_win("R5", n, SHORT_N);
        end else begin
          stay_done("R6");
        end
      end else begin
        @(negedge clk);
        chk_outs("R8", 1'b1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule